// File: doc/BRIEF.md
# Clause-22 Management Interface Master

This block runs IEEE 802.3 clause-22 management transactions toward a PHY. Software works it through two 32-bit words on a simple register port. A configuration word holds an enable bit and a clock divider for MDC. A command word holds the request and, once the frame is done, the result.

Writing the command word with its go bit set starts one frame. The go bit reads back as busy for as long as the frame is on the wire. For a write frame the data field is shifted out. For a read frame the 16 bits returned by the PHY replace the data field when busy drops.

The block drives MDC, drives MDIO through an output-enable pair, and samples the MDIO input. It handles one channel and does no background polling.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the configuration word (reg_sel = 0) reads 32'h8000_0000. Bit 31 reads 1 when no frame is in progress and 0 during a frame. Bit 30 is the enable bit and bits 7:0 are the divider; both are writable at any time.
- R2: The command word (reg_sel = 1) reads as {busy, write, 4'b0, register[4:0], phy[4:0], data[15:0]}, with busy in bit 31 and write in bit 30. After reset it reads 0.
- R3: A command-word write with bit 31 set, made while idle, starts a frame, and bit 31 then reads 1 until the frame ends. A write with bit 31 clear, made while idle, stores the other fields without starting a frame.
- R4: A command-word write made while busy is ignored. It neither changes the stored fields nor disturbs the frame in progress.
- R5: A write frame (bit 30 = 1) sends 64 bits, MSB first: 32 ones, 01, opcode 01, the PHY address, the register address, turnaround 10, and then the 16 data bits. MDIO is driven for the whole frame.
- R6: A read frame (bit 30 = 0) sends the same first 46 bits with opcode 10. It releases MDIO (mdio_oe = 0) from turnaround bit 46 to the end of the frame. It samples mdio_i at each of the last 16 MDC rising edges, MSB first, and the result appears in data[15:0] once busy clears.
- R7: Each MDC half period lasts (divider + 1) × HALF_BASE clock cycles. A frame keeps busy high for exactly 128 × (divider + 1) × HALF_BASE cycles.
- R8: MDC is low whenever no frame is in progress. While the enable bit is clear, MDC does not toggle and a started frame waits. The frame resumes once the enable bit is set.
- R9: During a frame, mdio_o and mdio_oe change only together with a falling edge of MDC.
- R10: mdio_oe is 0 whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | 0 selects the configuration word, 1 selects the command word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with DIV_W = 8 and HALF_BASE = 1. With these values a frame takes only 128 to 512 cycles, so dividers 0 to 3 can each be swept with both opcodes and several address and data patterns. A bench-side PHY records every bit at the MDC rising edges. It checks these bits against frames it assembles itself, and it answers read frames with known words. The short frames also leave room to test the enable gate and the command words rejected while busy.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int CMD_GO     = 31;
  localparam int CMD_WR     = 30;
  localparam int CFG_IDLE   = 31;
  localparam int CFG_EN     = 30;

  typedef struct packed {
    logic        wr;
    logic [4:0]  regad;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;

  // Whole frame, first bit on the wire in bit 63.
  function automatic logic [FRAME_BITS-1:0] frame_word(mdio_cmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.wr ? 2'b01 : 2'b10;
    ta = c.wr ? 2'b10 : 2'b00;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta,
            (c.wr ? c.data : 16'h0000)};
  endfunction

  // Clock cycles per MDC half period.
  function automatic logic [31:0] half_cycles(logic [31:0] div, logic [31:0] base);
    return (div + 32'd1) * base;
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int HALF_BASE = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam int CNT_W = DIV_W + $clog2(HALF_BASE + 1) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             tick;

  always_comb begin
    limit = CNT_W'(half_cycles(32'(div), 32'(HALF_BASE)) - 32'd1);
    tick  = active && en && (cnt == limit);
  end

  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!active) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (en) begin
      if (tick) begin
        cnt <= '0;
        mdc <= !mdc;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        active,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sreg;
  logic [IDX_W-1:0]      idx;
  logic                  is_wr;
  logic                  last_bit;

  assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
  assign done     = active && fall_tick && last_bit;
  assign mdio_o   = active ? sreg[FRAME_BITS-1] : 1'b1;
  assign mdio_oe  = active && (is_wr || (idx < IDX_W'(TA_POS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg    <= '0;
      idx     <= '0;
      is_wr   <= 1'b0;
      active  <= 1'b0;
      rd_data <= '0;
    end else if (start && !active) begin
      sreg   <= frame_word(cmd);
      idx    <= '0;
      is_wr  <= cmd.wr;
      active <= 1'b1;
    end else if (active) begin
      if (rise_tick && !is_wr && (idx >= IDX_W'(DATA_POS)))
        rd_data <= {rd_data[14:0], mdio_i};
      if (fall_tick) begin
        if (last_bit) begin
          active <= 1'b0;
        end else begin
          idx  <= idx + 1'b1;
          sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int HALF_BASE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CFG_PAD = 30 - DIV_W;

  logic             cfg_en;
  logic [DIV_W-1:0] cfg_div;
  mdio_cmd_t        cmd_q;
  mdio_cmd_t        cmd_new;

  // Named events for the checker.
  logic        eng_active;
  logic        cmd_wr_evt;
  logic        start_evt;
  logic        done_evt;
  logic        rise_evt;
  logic        fall_evt;
  logic [15:0] eng_rdata;

  assign cmd_new    = mdio_cmd_t'({reg_wdata[CMD_WR], reg_wdata[25:0]});
  assign cmd_wr_evt = reg_wr && reg_sel;
  assign start_evt  = cmd_wr_evt && reg_wdata[CMD_GO] && !eng_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_en  <= 1'b0;
      cfg_div <= '0;
      cmd_q   <= '0;
    end else begin
      if (reg_wr && !reg_sel) begin
        cfg_en  <= reg_wdata[CFG_EN];
        cfg_div <= reg_wdata[DIV_W-1:0];
      end
      if (cmd_wr_evt && !eng_active)
        cmd_q <= cmd_new;
      else if (done_evt && !cmd_q.wr)
        cmd_q.data <= eng_rdata;
    end
  end

  always_comb begin
    if (reg_sel)
      reg_rdata = {eng_active, cmd_q.wr, 4'b0000, cmd_q.regad, cmd_q.phy, cmd_q.data};
    else
      reg_rdata = {!eng_active, cfg_en, {CFG_PAD{1'b0}}, cfg_div};
  end

  mdio_clkgen #(.DIV_W(DIV_W), .HALF_BASE(HALF_BASE)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (eng_active),
    .en        (cfg_en),
    .div       (cfg_div),
    .mdc       (mdc),
    .rise_tick (rise_evt),
    .fall_tick (fall_evt)
  );

  mdio_frame_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .cmd       (cmd_new),
    .rise_tick (rise_evt),
    .fall_tick (fall_evt),
    .mdio_i    (mdio_i),
    .active    (eng_active),
    .done      (done_evt),
    .rd_data   (eng_rdata),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
  );
endmodule

// File: rtl/mdio_checker.sv
module mdio_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        en,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        cmd_wr_evt,
  input logic [10:0] cmd_hdr
);
  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc); // R8
  AST_MDC_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(mdc)); // R8
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc)); // R9
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $fell(mdio_oe)) |-> $fell(mdc)); // R6
  AST_BUSY_BLOCKS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr_evt) |=> $stable(cmd_hdr)); // R4
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe); // R10
endmodule

bind mdio_mgmt_master mdio_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (eng_active),
  .en         (cfg_en),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .cmd_wr_evt (cmd_wr_evt),
  .cmd_hdr    ({cmd_q.wr, cmd_q.regad, cmd_q.phy})
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Bench-side PHY state.
  int          rises = 0;
  logic [63:0] obs_o, obs_oe;
  logic [15:0] phy_val = '0;

  always #4 clk = !clk;

  mdio_mgmt_master #(.DIV_W(8), .HALF_BASE(1)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always @(posedge mdc) begin
    if (rises < 64) begin
      obs_o[63-rises]  = mdio_o;
      obs_oe[63-rises] = mdio_oe;
    end
    rises = rises + 1;
  end

  always @(negedge mdc) begin
    #1;
    if (rises >= 48 && rises < 64) mdio_i = phy_val[63-rises];
    else mdio_i = 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [31:0] d);
    reg_sel = sel;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [63:0] exp_frame(logic wr, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
    logic [63:0] f;
    f = '1;
    f[31:30] = 2'b01;
    f[29:28] = wr ? 2'b01 : 2'b10;
    f[27:23] = phy;
    f[22:18] = ra;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  // Waits out a running frame; returns the count of busy samples.
  task automatic wait_idle(output int n);
    logic [31:0] r;
    n = 0;
    rd_reg(1'b1, r);
    while (r[31] && n < 20000) begin
      n++;
      @(negedge clk);
      rd_reg(1'b1, r);
    end
  endtask

  task automatic xfer(input logic wr, input logic [4:0] phy, input logic [4:0] ra,
                      input logic [15:0] d, input logic [7:0] div, input logic [15:0] pv);
    int n;
    logic [31:0] r;
    logic [63:0] ef;
    wr_reg(1'b0, {2'b01, 22'd0, div});
    phy_val = pv;
    rises = 0;
    @(negedge clk);
    reg_sel = 1'b1; reg_wdata = {1'b1, wr, 4'b0, ra, phy, d}; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    wait_idle(n);
    chk(n == 128 * (int'(div) + 1), "R7 busy length", 64'(n), 64'(128 * (int'(div) + 1)));
    chk(rises == 64, "R7 mdc periods", 64'(rises), 64'd64);
    ef = exp_frame(wr, phy, ra, d);
    rd_reg(1'b1, r);
    if (wr) begin
      chk(obs_o == ef, "R5 write frame bits", obs_o, ef);
      chk(obs_oe == '1, "R5 write frame driven", obs_oe, '1);
      chk(r == {1'b0, 1'b1, 4'b0, ra, phy, d}, "R5 data kept", 64'(r), 64'({1'b0, 1'b1, 4'b0, ra, phy, d}));
    end else begin
      chk(obs_o[63:18] == ef[63:18], "R6 read frame header", 64'(obs_o[63:18]), 64'(ef[63:18]));
      chk(obs_oe == {{46{1'b1}}, 18'd0}, "R6 turnaround release", obs_oe, {{46{1'b1}}, 18'd0});
      chk(r[15:0] == pv, "R6 read data", 64'(r[15:0]), 64'(pv));
      chk(r[31:16] == {1'b0, 1'b0, 4'b0, ra, phy}, "R6 header kept", 64'(r[31:16]), 64'({6'b0, ra, phy}));
    end
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle outputs", {62'd0, mdc, mdio_oe}, 64'd0);
  endtask

  initial begin
    int cyc;
    for (cyc = 0; cyc < 150000; cyc++) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R2 reset values
    rd_reg(1'b0, r);
    chk(r == 32'h8000_0000, "R1 config reset", 64'(r), 64'h8000_0000);
    rd_reg(1'b1, r);
    chk(r == 32'h0, "R2 command reset", 64'(r), 64'h0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 reset outputs", {62'd0, mdc, mdio_oe}, 64'd0);

    // R1 config write/readback
    wr_reg(1'b0, 32'h4000_00A5);
    rd_reg(1'b0, r);
    chk(r == 32'hC000_00A5, "R1 config readback", 64'(r), 64'hC000_00A5);

    // R3, R2: store without starting
    wr_reg(1'b1, {1'b0, 1'b1, 4'b0, 5'h13, 5'h0A, 16'hBEEF});
    repeat (5) @(negedge clk);
    rd_reg(1'b1, r);
    chk(r == {1'b0, 1'b1, 4'b0, 5'h13, 5'h0A, 16'hBEEF}, "R3 store without go",
        64'(r), 64'({1'b0, 1'b1, 4'b0, 5'h13, 5'h0A, 16'hBEEF}));
    chk(mdc == 1'b0, "R3 no frame started", 64'(mdc), 64'd0);

    // Sweep dividers and opcodes (R5, R6, R7)
    for (int dv = 0; dv < 4; dv++) begin
      xfer(1'b1, 5'(dv * 7 + 1), 5'(31 - dv), 16'hA5C3 ^ 16'(dv * 16'h1111), 8'(dv), 16'h0);
      xfer(1'b0, 5'(dv + 16), 5'(dv * 5), 16'h0, 8'(dv), 16'h5A3C ^ 16'(dv * 16'h0F0F));
      xfer(1'b1, 5'h1F, 5'h00, 16'h0001 << dv, 8'(dv), 16'h0);
      xfer(1'b0, 5'h00, 5'h1F, 16'hFFFF, 8'(dv), 16'h8001 >> dv);
    end

    // R1 idle bit during a frame, R4 command ignored while busy
    wr_reg(1'b0, {2'b01, 22'd0, 8'd2});
    rises = 0;
    wr_reg(1'b1, {1'b1, 1'b1, 4'b0, 5'h05, 5'h09, 16'h1234});
    repeat (20) @(negedge clk);
    rd_reg(1'b0, r);
    chk(r[31] == 1'b0, "R1 idle low while busy", 64'(r[31]), 64'd0);
    rd_reg(1'b1, r);
    chk(r[31] == 1'b1, "R3 busy reads one", 64'(r[31]), 64'd1);
    wr_reg(1'b1, {1'b1, 1'b0, 4'b0, 5'h1A, 5'h11, 16'h9999});
    wait_idle(n);
    chk(n == 384 - 22, "R4 frame length unchanged", 64'(n), 64'(384 - 22));
    chk(obs_o == exp_frame(1'b1, 5'h09, 5'h05, 16'h1234), "R4 frame undisturbed",
        obs_o, exp_frame(1'b1, 5'h09, 5'h05, 16'h1234));
    rd_reg(1'b1, r);
    chk(r == {1'b0, 1'b1, 4'b0, 5'h05, 5'h09, 16'h1234}, "R4 fields unchanged",
        64'(r), 64'({1'b0, 1'b1, 4'b0, 5'h05, 5'h09, 16'h1234}));

    // R8 enable gate
    wr_reg(1'b0, {2'b00, 22'd0, 8'd1});
    rises = 0;
    phy_val = 16'hC0DE;
    wr_reg(1'b1, {1'b1, 1'b0, 4'b0, 5'h02, 5'h03, 16'h0});
    begin
      bit moved;
      moved = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (mdc) moved = 1'b1;
      end
      chk(!moved && rises == 0, "R8 mdc held while disabled", 64'(rises), 64'd0);
    end
    rd_reg(1'b1, r);
    chk(r[31] == 1'b1, "R8 frame waits while disabled", 64'(r[31]), 64'd1);
    wr_reg(1'b0, {2'b01, 22'd0, 8'd1});
    wait_idle(n);
    rd_reg(1'b1, r);
    chk(r[15:0] == 16'hC0DE, "R8 frame resumes and completes", 64'(r[15:0]), 64'hC0DE);
    chk(rises == 64, "R8 full frame after enable", 64'(rises), 64'd64);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule